// File: doc/BRIEF.md
# Per-Area External Bus Access Controller

This block converts a processor's requests to external address space into external bus cycles. The address space is split into eight equal areas, selected by the top three address bits. Each area has three settings: a data bus width of 8 or 16 bits, a basic cycle of two or three states, and a count of 0 to 3 automatic wait states. The block generates the address strobe, read and write strobes and byte-lane enables, and it steps through the bus states for every access.

A word access to an 8-bit area runs as two byte cycles, one after the other. Read data returns with a single done pulse once the whole access has finished. The block also reports a global bus mode. That mode is 16-bit when any area is set to 16-bit, or when a burst-ROM option input is high. The area settings are captured when an access starts, so a settings write takes effect only from the next access.

Top module: `xbus_area_ctrl`

## Requirements
- R1: The area index is `req_addr[23:21]`. Area i takes its width from bit i of the width register (1 = 16-bit), its state count from bit i of the state register (1 = 3-state) and its wait count from bits 2i+1:2i of the wait register. `cfg_sel` picks the register to write: 0 = width (`cfg_wdata[7:0]`), 1 = state (`cfg_wdata[7:0]`), 2 = wait (`cfg_wdata[15:0]`), 3 = none.
- R2: `bus_mode16` is 1 when any width bit is 1 or `burst_rom_en` is 1, and is 0 otherwise. It follows a width write from the cycle after that write.
- R3: In a 2-state area, each bus cycle holds `ext_as` high for 2 clocks and the read or write strobe high for the last 1 of them. The wait field is ignored.
- R4: In a 3-state area with wait count N, each bus cycle holds `ext_as` high for 3+N clocks and the read or write strobe high for the last 2+N of them.
- R5: A word access (`req_size16`=1) to an 8-bit area runs two bus cycles. The first is at the even address and carries the upper byte; the second is at the odd address and carries the lower byte. Both use lane enable `ext_be`=2'b10, and write data travels on `ext_dout[15:8]`.
- R6: In a 16-bit area, a word access uses `ext_be`=2'b11 in a single cycle. A byte access uses 2'b10 (upper lane) at an even address and 2'b01 (lower lane) at an odd address. Byte write data appears on the selected lane. `ext_be[1]` is the lane `ext_dout[15:8]`/`ext_din[15:8]`.
- R7: `done` is high for exactly one clock, the clock after the last bus state. `rd_data` is valid in that clock. A word read returns the even-address byte in `rd_data[15:8]`. A byte read returns its byte in `rd_data[7:0]`, with the upper byte 0. An 8-bit area is read on the upper lane.
- R8: Area settings are captured when an access is accepted. A register write made during an access does not change that access's timing, but does apply to the next one.
- R9: After reset the block is idle with all strobes, `done` and `busy` low. The width register resets to 0, the state register to all ones, and the wait register to all ones.
- R10: A request is accepted only while `busy` is low. A request or a changed address presented while busy starts no extra bus cycle and does not alter the one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Settings register write strobe |
| cfg_sel | input | 2 | Register select: 0 width, 1 state, 2 wait |
| cfg_wdata | input | 16 | Settings write data |
| burst_rom_en | input | 1 | Burst-ROM option; forces global 16-bit mode |
| req | input | 1 | Access request |
| req_addr | input | 24 | Access byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = word access, 0 = byte access |
| req_wdata | input | 16 | Write data (byte access uses bits 7:0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read data, valid with done |
| bus_mode16 | output | 1 | Global bus mode, 1 = 16-bit |
| ext_addr | output | 24 | External address |
| ext_as | output | 1 | Address strobe |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_be | output | 2 | Byte-lane enables, bit 1 = upper lane |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
The hardest situation to reach is a settings write that lands while an access is already in its bus states, since the result must show up in the next access and not in the current one. The stimulus issues the write on the clock just after the request is accepted. The address strobe is counted for that access and then for the one after it. The same method covers a request whose address changes in the middle of a busy access. It also covers the back-to-back pair of byte cycles in a split word access, where the address strobe never falls between the two halves, so the halves are told apart by the strobe rising edges and the change in address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int WAIT_W = 2;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] SEL_WIDTH = 2'd0;
    localparam logic [1:0] SEL_STATE = 2'd1;
    localparam logic [1:0] SEL_WAIT  = 2'd2;

    typedef struct packed {
        logic              wide;
        logic              three;
        logic [WAIT_W-1:0] waits;
    } area_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_TW   = 3'd3,
        S_T3   = 3'd4
    } bstate_t;
endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int N_AREA = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [N_AREA*WAIT_W-1:0] cfg_wdata,
    input  logic                     burst_rom_en,
    output logic [N_AREA-1:0]        width_q,
    output logic [N_AREA-1:0]        state_q,
    output logic [N_AREA*WAIT_W-1:0] wait_q,
    output logic                     bus_mode16
);
    typedef struct packed {
        logic [N_AREA-1:0]        wid;
        logic [N_AREA-1:0]        st;
        logic [N_AREA*WAIT_W-1:0] wt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_WIDTH: r_d.wid = cfg_wdata[N_AREA-1:0];
                SEL_STATE: r_d.st  = cfg_wdata[N_AREA-1:0];
                SEL_WAIT:  r_d.wt  = cfg_wdata;
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.wid <= '0;
            r_q.st  <= '1;
            r_q.wt  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign width_q    = r_q.wid;
    assign state_q    = r_q.st;
    assign wait_q     = r_q.wt;
    assign bus_mode16 = burst_rom_en | (|r_q.wid);

    // R2: a nonzero width write turns on the global 16-bit mode
    assert_mode_follows_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_WIDTH && (|cfg_wdata[N_AREA-1:0])) |=> bus_mode16);
endmodule

// File: rtl/xbus_area_lut.sv
module xbus_area_lut
    import xbus_pkg::*;
#(
    parameter int AREA_BITS = 3,
    localparam int N_AREA = 1 << AREA_BITS
) (
    input  logic [N_AREA-1:0]        width_q,
    input  logic [N_AREA-1:0]        state_q,
    input  logic [N_AREA*WAIT_W-1:0] wait_q,
    input  logic [AREA_BITS-1:0]     area,
    output area_cfg_t                area_cfg
);
    area_cfg_t cfg_arr [N_AREA];

    for (genvar i = 0; i < N_AREA; i++) begin : g_area
        assign cfg_arr[i].wide  = width_q[i];
        assign cfg_arr[i].three = state_q[i];
        assign cfg_arr[i].waits = wait_q[i*WAIT_W +: WAIT_W];
    end

    assign area_cfg = cfg_arr[area];
endmodule

// File: rtl/xbus_area_ctrl.sv
module xbus_area_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int AREA_BITS = 3,
    localparam int N_AREA   = 1 << AREA_BITS,
    localparam int CFG_W    = N_AREA * WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              burst_rom_en,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic              req_size16,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_mode16,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_as,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic [1:0]        ext_be,
    output logic [DATA_W-1:0] ext_dout,
    input  logic [DATA_W-1:0] ext_din
);
    logic [N_AREA-1:0] width_q, state_q;
    logic [CFG_W-1:0]  wait_q;
    area_cfg_t         lut_cfg;

    xbus_cfg_regs #(.N_AREA(N_AREA)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .burst_rom_en(burst_rom_en),
        .width_q(width_q), .state_q(state_q), .wait_q(wait_q),
        .bus_mode16(bus_mode16)
    );

    xbus_area_lut #(.AREA_BITS(AREA_BITS)) u_lut (
        .width_q(width_q), .state_q(state_q), .wait_q(wait_q),
        .area(req_addr[ADDR_W-1 -: AREA_BITS]), .area_cfg(lut_cfg)
    );

    typedef struct packed {
        bstate_t           state;
        area_cfg_t         cur;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              sz16;
        logic              split;
        logic              second;
        logic [DATA_W-1:0] wdata;
        logic [WAIT_W-1:0] wcnt;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t q_d, q_q;
    logic last_st;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        last_st  = (q_q.state == S_T3) || (q_q.state == S_T2 && !q_q.cur.three);
        case (q_q.state)
            S_IDLE: if (req) begin
                q_d.state  = S_T1;
                q_d.cur    = lut_cfg;
                q_d.we     = req_we;
                q_d.sz16   = req_size16;
                q_d.split  = req_size16 && !lut_cfg.wide;
                q_d.second = 1'b0;
                q_d.wdata  = req_wdata;
                q_d.rdata  = '0;
                q_d.addr   = req_size16 ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
            end
            S_T1: q_d.state = S_T2;
            S_T2: if (q_q.cur.three) begin
                if (q_q.cur.waits != '0) begin
                    q_d.state = S_TW;
                    q_d.wcnt  = q_q.cur.waits;
                end else begin
                    q_d.state = S_T3;
                end
            end
            S_TW: begin
                if (q_q.wcnt == WAIT_W'(1)) q_d.state = S_T3;
                q_d.wcnt = q_q.wcnt - WAIT_W'(1);
            end
            default: ;
        endcase
        if (last_st) begin
            if (!q_q.we) begin
                if (q_q.split) begin
                    if (q_q.second) q_d.rdata[BYTE_W-1:0]       = ext_din[DATA_W-1 -: BYTE_W];
                    else            q_d.rdata[DATA_W-1 -: BYTE_W] = ext_din[DATA_W-1 -: BYTE_W];
                end else if (q_q.sz16) begin
                    q_d.rdata = ext_din;
                end else if (!q_q.cur.wide || !q_q.addr[0]) begin
                    q_d.rdata = {{BYTE_W{1'b0}}, ext_din[DATA_W-1 -: BYTE_W]};
                end else begin
                    q_d.rdata = {{BYTE_W{1'b0}}, ext_din[BYTE_W-1:0]};
                end
            end
            if (q_q.split && !q_q.second) begin
                q_d.state   = S_T1;
                q_d.second  = 1'b1;
                q_d.addr[0] = 1'b1;
            end else begin
                q_d.state = S_IDLE;
                q_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.state <= S_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    logic strobe_ph;
    assign strobe_ph = (q_q.state == S_T2) || (q_q.state == S_TW) || (q_q.state == S_T3);
    assign busy      = (q_q.state != S_IDLE);
    assign ext_as    = busy;
    assign ext_rd    = strobe_ph && !q_q.we;
    assign ext_wr    = strobe_ph && q_q.we;
    assign ext_addr  = q_q.addr;
    assign done      = q_q.done;
    assign rd_data   = q_q.rdata;

    always_comb begin
        ext_be   = 2'b00;
        ext_dout = '0;
        if (busy) begin
            if (!q_q.cur.wide) begin
                ext_be   = 2'b10;
                ext_dout = q_q.split
                         ? {2{(q_q.second ? q_q.wdata[BYTE_W-1:0] : q_q.wdata[DATA_W-1 -: BYTE_W])}}
                         : {2{q_q.wdata[BYTE_W-1:0]}};
            end else if (q_q.sz16) begin
                ext_be   = 2'b11;
                ext_dout = q_q.wdata;
            end else begin
                ext_be   = q_q.addr[0] ? 2'b01 : 2'b10;
                ext_dout = {2{q_q.wdata[BYTE_W-1:0]}};
            end
        end
    end

    // R3: a 2-state area never enters a wait or third state
    assert_two_state_no_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == S_T2 && !q_q.cur.three) |=> (q_q.state == S_IDLE || q_q.state == S_T1));

    // R4: the third state is reached only from T2 or from a wait state
    assert_t3_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == S_T3) |-> ($past(q_q.state) == S_T2 || $past(q_q.state) == S_TW));

    // R5: a second byte cycle occurs only for a split word access
    assert_second_is_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == S_T1 && q_q.second) |-> q_q.split);

    // R6: a byte cycle drives exactly one lane
    assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_as && (!q_q.sz16 || q_q.split)) |-> ($countones(ext_be) == 1));

    // R7: done is a single-clock pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: captured area settings hold while an access runs
    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q_q.cur));

    // R3: strobes never overlap and only occur inside an address strobe
    always_comb begin
        assert_strobe_excl_R3: assert (!(ext_rd && ext_wr));
        assert_strobe_in_as_R4: assert (!(ext_rd || ext_wr) || ext_as);
    end
endmodule

// File: tb/xbus_area_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_area_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [15:0] cfg_wdata = '0;
    logic        burst_rom_en = 1'b0;
    logic        req = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic        req_size16 = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, bus_mode16, ext_as, ext_rd, ext_wr;
    logic [15:0] rd_data, ext_dout, ext_din;
    logic [23:0] ext_addr;
    logic [1:0]  ext_be;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    assign ext_din = {memf(ext_addr), memf(ext_addr | 24'h1)};

    xbus_area_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .burst_rom_en(burst_rom_en), .req(req),
        .req_addr(req_addr), .req_we(req_we), .req_size16(req_size16),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .bus_mode16(bus_mode16), .ext_addr(ext_addr), .ext_as(ext_as),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_be(ext_be),
        .ext_dout(ext_dout), .ext_din(ext_din)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  w;
        logic [7:0]  s;
        logic [15:0] wt;
        logic [23:0] a;
        logic        we;
        logic        sz;
        logic [15:0] wd;
        logic [7:0]  nas;
        logic [7:0]  nbus;
        logic [15:0] rd;
        logic [1:0]  be;
        logic [23:0] a0;
        logic [15:0] d0;
        logic [23:0] a1;
        logic [15:0] d1;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 16'hFFFF, 24'h000010, 1'b0, 1'b0, 16'h0000, 8'd2, 8'd1, 16'h004A, 2'b10, 24'h000010, 16'h0, 24'h0, 16'h0},
        '{8'h00, 8'h01, 16'h0002, 24'h000020, 1'b0, 1'b0, 16'h0000, 8'd5, 8'd1, 16'h007A, 2'b10, 24'h000020, 16'h0, 24'h0, 16'h0},
        '{8'h02, 8'h02, 16'h000C, 24'h200040, 1'b0, 1'b1, 16'h0000, 8'd6, 8'd1, 16'h1A1B, 2'b11, 24'h200040, 16'h0, 24'h0, 16'h0},
        '{8'h00, 8'h00, 16'h0000, 24'h400050, 1'b0, 1'b1, 16'h0000, 8'd4, 8'd2, 16'h0A0B, 2'b10, 24'h400050, 16'h0, 24'h400051, 16'h0},
        '{8'h80, 8'h80, 16'h4000, 24'hE00061, 1'b0, 1'b0, 16'h0000, 8'd4, 8'd1, 16'h003B, 2'b01, 24'hE00061, 16'h0, 24'h0, 16'h0},
        '{8'h80, 8'h80, 16'h4000, 24'hC00061, 1'b0, 1'b0, 16'h0000, 8'd2, 8'd1, 16'h003B, 2'b10, 24'hC00061, 16'h0, 24'h0, 16'h0},
        '{8'h00, 8'h08, 16'h0000, 24'h600070, 1'b1, 1'b1, 16'hBEEF, 8'd6, 8'd2, 16'h0000, 2'b10, 24'h600070, 16'hBE00, 24'h600071, 16'hEF00},
        '{8'h00, 8'h00, 16'hFFFF, 24'hA00000, 1'b1, 1'b0, 16'h0033, 8'd2, 8'd1, 16'h0000, 2'b10, 24'hA00000, 16'h3300, 24'h0, 16'h0},
        '{8'h10, 8'h00, 16'h0000, 24'h800002, 1'b1, 1'b0, 16'h00C3, 8'd2, 8'd1, 16'h0000, 2'b10, 24'h800002, 16'hC300, 24'h0, 16'h0},
        '{8'h10, 8'h00, 16'h0000, 24'h800003, 1'b1, 1'b0, 16'h00A5, 8'd2, 8'd1, 16'h0000, 2'b01, 24'h800003, 16'h00A5, 24'h0, 16'h0},
        '{8'h10, 8'h10, 16'h0200, 24'h800004, 1'b1, 1'b1, 16'h1234, 8'd5, 8'd1, 16'h0000, 2'b11, 24'h800004, 16'h1234, 24'h0, 16'h0},
        '{8'h00, 8'h04, 16'h0030, 24'h4000FF, 1'b0, 1'b0, 16'h0000, 8'd6, 8'd1, 16'h00A5, 2'b10, 24'h4000FF, 16'h0, 24'h0, 16'h0}
    };

    int          as_cnt, bus_cnt, done_cnt;
    logic [15:0] rd_val;
    logic [23:0] la [2];
    logic [15:0] ld [2];
    logic [1:0]  lb [2];
    logic        done_after, busy_after, as_after;
    bit          finished = 0;

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    // mode 0: plain; mode 1: settings write on first busy clock; mode 2: request held with new address
    task automatic run_access(input logic [23:0] a, input logic we, input logic sz, input logic [15:0] wd,
                              input int mode, input logic [1:0] msel, input logic [15:0] mdata);
        bit   first = 1;
        bit   got = 0;
        bit   prev = 0;
        int   guard = 0;
        as_cnt = 0; bus_cnt = 0; done_cnt = 0; rd_val = '0;
        for (int i = 0; i < 2; i++) begin la[i] = '0; ld[i] = '0; lb[i] = '0; end
        @(negedge clk);
        req = 1'b1; req_addr = a; req_we = we; req_size16 = sz; req_wdata = wd;
        while (!got && guard < 100) begin
            @(negedge clk);
            guard++;
            if (first) begin
                first = 0;
                if (mode == 2) req_addr = 24'hE00000;
                else req = 1'b0;
                if (mode == 1) begin cfg_we = 1'b1; cfg_sel = msel; cfg_wdata = mdata; end
            end else if (mode == 1) begin
                cfg_we = 1'b0; cfg_sel = 2'd3;
            end
            if (ext_as) as_cnt++;
            if ((ext_rd || ext_wr) && !prev) begin
                if (bus_cnt < 2) begin la[bus_cnt] = ext_addr; ld[bus_cnt] = ext_dout; lb[bus_cnt] = ext_be; end
                bus_cnt++;
            end
            prev = ext_rd || ext_wr;
            if (done) begin done_cnt++; got = 1; rd_val = rd_data; req = 1'b0; end
        end
        if (!got) chk(0, "R7 done never seen", 32'(guard), 32'd100);
        @(negedge clk);
        done_after = done; busy_after = busy; as_after = ext_as;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!ext_as && !ext_rd && !ext_wr, "R9 strobes in reset", {ext_as, ext_rd, ext_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R9 done/busy after reset", {done, busy}, 0);
        chk(bus_mode16 == 1'b0, "R9 reset width gives 8-bit mode", bus_mode16, 0);

        // R9: reset settings are 3-state with 3 waits, 8-bit
        run_access(24'h000100, 1'b0, 1'b0, 16'h0, 0, 2'd3, 16'h0);
        chk(as_cnt == 6, "R9 reset timing as-cycles", as_cnt, 6);
        chk(rd_val == 16'h005A, "R9 reset read data", rd_val, 16'h005A);

        // Vector table: R1 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            cfg_write(2'd0, {8'h00, VECS[v].w});
            cfg_write(2'd1, {8'h00, VECS[v].s});
            cfg_write(2'd2, VECS[v].wt);
            run_access(VECS[v].a, VECS[v].we, VECS[v].sz, VECS[v].wd, 0, 2'd3, 16'h0);
            chk(as_cnt == int'(VECS[v].nas), $sformatf("R3 R4 vec%0d as-cycles", v), as_cnt, VECS[v].nas);
            chk(bus_cnt == int'(VECS[v].nbus), $sformatf("R5 vec%0d bus cycles", v), bus_cnt, VECS[v].nbus);
            chk(la[0] == VECS[v].a0, $sformatf("R1 vec%0d first address", v), la[0], VECS[v].a0);
            chk(lb[0] == VECS[v].be, $sformatf("R6 vec%0d lane enables", v), lb[0], VECS[v].be);
            chk(done_cnt == 1 && !done_after && !busy_after, $sformatf("R7 vec%0d done pulse", v),
                {done_cnt[7:0], done_after, busy_after}, 32'h100);
            if (!VECS[v].we)
                chk(rd_val == VECS[v].rd, $sformatf("R7 vec%0d read data", v), rd_val, VECS[v].rd);
            else
                chk((ld[0] & {{8{lb[0][1]}}, {8{lb[0][0]}}}) == VECS[v].d0,
                    $sformatf("R6 vec%0d write lane data", v),
                    ld[0] & {{8{lb[0][1]}}, {8{lb[0][0]}}}, VECS[v].d0);
            if (VECS[v].nbus == 8'd2) begin
                chk(la[1] == VECS[v].a1 && lb[1] == 2'b10, $sformatf("R5 vec%0d second address", v),
                    {lb[1], la[1]}, {2'b10, VECS[v].a1});
                if (VECS[v].we)
                    chk((ld[1] & 16'hFF00) == VECS[v].d1, $sformatf("R5 vec%0d second byte", v),
                        ld[1] & 16'hFF00, VECS[v].d1);
            end
        end

        // R2: global bus mode
        cfg_write(2'd0, 16'h0004);
        chk(bus_mode16 == 1'b1, "R2 one 16-bit area sets mode", bus_mode16, 1);
        cfg_write(2'd0, 16'h0000);
        chk(bus_mode16 == 1'b0, "R2 all 8-bit clears mode", bus_mode16, 0);
        @(negedge clk); burst_rom_en = 1'b1;
        @(negedge clk);
        chk(bus_mode16 == 1'b1, "R2 burst option forces 16-bit", bus_mode16, 1);
        burst_rom_en = 1'b0;
        @(negedge clk);
        chk(bus_mode16 == 1'b0, "R2 burst option released", bus_mode16, 0);

        // R8: settings write during an access applies to the next one
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd2, 16'h0003);
        run_access(24'h000008, 1'b0, 1'b0, 16'h0, 1, 2'd1, 16'h0001);
        chk(as_cnt == 2, "R8 current access keeps old timing", as_cnt, 2);
        run_access(24'h000008, 1'b0, 1'b0, 16'h0, 0, 2'd3, 16'h0);
        chk(as_cnt == 6, "R8 next access uses new timing", as_cnt, 6);

        // R10: request held while busy with a changed address
        cfg_write(2'd1, 16'h0000);
        run_access(24'h000005, 1'b0, 1'b0, 16'h0, 2, 2'd3, 16'h0);
        chk(bus_cnt == 1 && as_cnt == 2, "R10 no extra bus cycle", {bus_cnt[7:0], as_cnt[7:0]}, 16'h0102);
        chk(la[0] == 24'h000005, "R10 address not altered", la[0], 24'h000005);
        chk(!busy_after && !as_after, "R10 idle after access", {busy_after, as_after}, 0);
        chk(rd_val == 16'h005F, "R10 read data of accepted access", rd_val, 16'h005F);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule